// File: doc/BRIEF.md
# LCD Backplane and Segment Drive Sequencer

This block turns a stored display image into the time-ordered drive codes for a segmented liquid crystal panel. It runs from a clock that is already divided down from the panel oscillator. It counts a programmable number of clock cycles per drive phase and walks through the phases of each display frame. For every backplane and every segment it produces a registered 2-bit level code. An analog stage outside the block turns each code into a real voltage. The block takes two banks of segment bits from the serial loader in front of it. It copies them into its own display registers only at the boundary between frames, so a frame is never drawn from a mixture of old and new data.

Two drive schemes are supported. In static drive a single backplane toggles between high and low, and every segment is driven in phase with it (off) or against it (on). In two-way multiplexed drive a frame has four phases. In each phase one backplane is driven high or low while the other rests at mid level. Segments then use bank A while backplane 1 is active and bank B while backplane 2 is active. On pixels see the full swing, and the two halves of each backplane's active period cancel, so the panel carries no net DC.

When several such blocks share a panel, one acts as the timing master. The others are set to follow: they release their backplane pins and take their phase from the backplane levels they observe on those pins.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: While reset is asserted, and on the first edge after it, every backplane and segment output carries the low code and `bp_oe_o` is 0. The display registers start all-off, so segments show blank data until the first frame boundary.
- R2: Level codes are 2'b00 = low, 2'b01 = mid, 2'b10 = high, and 2'b11 never appears on any output. Segment i uses bits [2i+1:2i] of `seg_o`.
- R3: In master static mode (`mux2_i`=0, `slave_i`=0) each phase lasts PHASE_DIV cycles. A frame is two phases: `bp1_o` is high in the first and low in the second, and `bp2_o` stays low.
- R4: In static mode segment i takes its bit from bank A. An on segment is driven with the opposite level to `bp1_o` (high becomes low and low becomes high), and an off segment with the same level.
- R5: In master multiplexed mode (`mux2_i`=1) a frame has four phases of PHASE_DIV cycles each, in the order bp1 high, bp1 low, bp2 high, bp2 low. The backplane not active in a phase is held at mid.
- R6: In multiplexed mode, during the two bp1 phases segment i uses bank A bit i, and during the two bp2 phases it uses bank B bit i. An on segment takes the opposite of the active backplane's level and an off segment the same level, so segment codes are never mid.
- R7: The banks are captured only on the clock edge that ends a frame. Values present on that edge appear from the first phase of the next frame, and bank changes made at any other time do not appear until the frame after.
- R8: With `slave_i`=1, `bp_oe_o` is 0 from the next edge on. The phase is decoded from `bp1_in_i`/`bp2_in_i` in the current mode: bp1 high gives phase 0, bp1 low gives 1, bp2 high gives 2 and bp2 low gives 3, where in multiplexed mode the other input must be mid. Segment codes follow that phase two edges after the inputs change, and entry to phase 0 from another phase is a frame boundary.
- R9: In slave mode an input pattern that decodes to no phase (for example both mid, or both high) leaves the phase and the segment codes unchanged.
- R10: A change of `mux2_i` restarts timing at phase 0 on the next edge and counts as a frame boundary, so the banks are captured. The outputs follow the new mode from the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| mux2_i | input | 1 | 1 = two-backplane multiplexed drive, 0 = static drive |
| slave_i | input | 1 | 1 = follow external backplane timing (oscillator tied low) |
| bank_a_i | input | NSEG | Latch bank A from the serial loader (static and bp1 data) |
| bank_b_i | input | NSEG | Latch bank B from the serial loader (bp2 data) |
| bp1_in_i | input | 2 | Observed level code of backplane 1 in slave mode |
| bp2_in_i | input | 2 | Observed level code of backplane 2 in slave mode |
| bp1_o | output | 2 | Backplane 1 drive code |
| bp2_o | output | 2 | Backplane 2 drive code |
| bp_oe_o | output | 1 | 1 = backplane pins driven by this block |
| seg_o | output | 2*NSEG | Segment drive codes, two bits per segment |

## Verification
The frame-boundary capture of the banks and a change of the banks by the serial loader can land on the same clock edge. The bench provokes this by presenting new bank contents in the cycle just before the edge that closes a frame, then replacing them again one cycle later. The whole next frame must show the first replacement and none of the second, and the second must appear only from the frame after. A mode switch arriving in the middle of a phase is handled the same way, since it is both a restart and a capture. It is judged by the phase order, the phase lengths and the captured data that follow.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  typedef enum logic [1:0] {
    LV_LOW  = 2'b00,
    LV_MID  = 2'b01,
    LV_HIGH = 2'b10
  } lvl_t;

  // Level used on an active backplane in the given phase: even phases high.
  function automatic lvl_t active_level(input logic [1:0] ph);
    return ph[0] ? LV_LOW : LV_HIGH;
  endfunction

  function automatic lvl_t opposite(input lvl_t l);
    return (l == LV_HIGH) ? LV_LOW : LV_HIGH;
  endfunction

endpackage

// File: rtl/lcdseq_timebase.sv
module lcdseq_timebase
  import lcdseq_pkg::*;
#(
  parameter int PHASE_DIV = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mux2_i,
  input  logic       slave_i,
  input  logic [1:0] bp1_in_i,
  input  logic [1:0] bp2_in_i,
  output logic [1:0] phase_o,
  output logic       mode_o,
  output logic       wrap_o
);

  localparam int CW = (PHASE_DIV > 1) ? $clog2(PHASE_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [1:0]    phase_q;
  logic          mode_q;
  logic [1:0]    last;
  logic          tick;
  logic          restart;
  logic          dec_ok;
  logic [1:0]    dec_ph;

  always_comb begin
    last    = mode_q ? 2'd3 : 2'd1;
    tick    = (cnt_q == CNT_LAST);
    restart = (mux2_i != mode_q);
    dec_ok  = 1'b0;
    dec_ph  = 2'd0;
    if (mode_q) begin
      if (bp2_in_i == LV_MID && bp1_in_i == LV_HIGH) begin dec_ok = 1'b1; dec_ph = 2'd0; end
      else if (bp2_in_i == LV_MID && bp1_in_i == LV_LOW) begin dec_ok = 1'b1; dec_ph = 2'd1; end
      else if (bp1_in_i == LV_MID && bp2_in_i == LV_HIGH) begin dec_ok = 1'b1; dec_ph = 2'd2; end
      else if (bp1_in_i == LV_MID && bp2_in_i == LV_LOW) begin dec_ok = 1'b1; dec_ph = 2'd3; end
    end else begin
      if (bp1_in_i == LV_HIGH) begin dec_ok = 1'b1; dec_ph = 2'd0; end
      else if (bp1_in_i == LV_LOW) begin dec_ok = 1'b1; dec_ph = 2'd1; end
    end
    if (restart)
      wrap_o = 1'b1;
    else if (slave_i)
      wrap_o = dec_ok && (dec_ph == 2'd0) && (phase_q != 2'd0);
    else
      wrap_o = tick && (phase_q == last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 2'd0;
      mode_q  <= mux2_i;
    end else if (restart) begin
      cnt_q   <= '0;
      phase_q <= 2'd0;
      mode_q  <= mux2_i;
    end else if (slave_i) begin
      cnt_q <= '0;
      if (dec_ok) phase_q <= dec_ph;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick) phase_q <= (phase_q == last) ? 2'd0 : phase_q + 2'd1;
    end
  end

  assign phase_o = phase_q;
  assign mode_o  = mode_q;

  // R5 / R3: master phases step by one and wrap after the last phase of the frame
  p_phase_order_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(slave_i) && !$past(restart) && phase_q != $past(phase_q))
      |-> (phase_q == (($past(phase_q) == $past(last)) ? 2'd0 : $past(phase_q) + 2'd1)));

  // R9: an undecodable slave input pattern holds the phase
  p_slave_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(slave_i) && !$past(dec_ok) && !$past(restart))
      |-> $stable(phase_q));

endmodule

// File: rtl/lcdseq_frame_store.sv
module lcdseq_frame_store #(
  parameter int NSEG = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [NSEG-1:0] bank_a_i,
  input  logic [NSEG-1:0] bank_b_i,
  output logic [NSEG-1:0] disp_a_o,
  output logic [NSEG-1:0] disp_b_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_a_o <= '0;
      disp_b_o <= '0;
    end else if (load_i) begin
      disp_a_o <= bank_a_i;
      disp_b_o <= bank_b_i;
    end
  end

  // R7: displayed image changes only on a frame boundary
  p_hold_midframe_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_i)) |-> ($stable(disp_a_o) && $stable(disp_b_o)));

endmodule

// File: rtl/lcdseq_drive.sv
module lcdseq_drive
  import lcdseq_pkg::*;
#(
  parameter int NSEG = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        phase_i,
  input  logic              mode_i,
  input  logic [NSEG-1:0]   disp_a_i,
  input  logic [NSEG-1:0]   disp_b_i,
  output logic [1:0]        bp1_o,
  output logic [1:0]        bp2_o,
  output logic [2*NSEG-1:0] seg_o
);

  lvl_t              act;
  lvl_t              inv;
  lvl_t              bp1_n;
  lvl_t              bp2_n;
  logic [NSEG-1:0]   pick;
  logic [2*NSEG-1:0] seg_n;
  logic              mode_r;

  always_comb begin
    act = active_level(phase_i);
    inv = opposite(act);
    if (!mode_i) begin
      bp1_n = act;
      bp2_n = LV_LOW;
    end else if (!phase_i[1]) begin
      bp1_n = act;
      bp2_n = LV_MID;
    end else begin
      bp1_n = LV_MID;
      bp2_n = act;
    end
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign pick[g] = (mode_i && phase_i[1]) ? disp_b_i[g] : disp_a_i[g];
    assign seg_n[2*g +: 2] = pick[g] ? inv : act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp1_o  <= LV_LOW;
      bp2_o  <= LV_LOW;
      seg_o  <= '0;
      mode_r <= 1'b0;
    end else begin
      bp1_o  <= bp1_n;
      bp2_o  <= bp2_n;
      seg_o  <= seg_n;
      mode_r <= mode_i;
    end
  end

  // R5: in multiplexed drive exactly one backplane leaves the mid level
  p_one_active_bp_r5: assert property (@(posedge clk) disable iff (rst)
    mode_r |-> ((bp1_o != LV_MID) != (bp2_o != LV_MID)));

  // R3: static drive parks bp2 low and never rests bp1 at mid
  p_static_bp_r3: assert property (@(posedge clk) disable iff (rst)
    !mode_r |-> (bp2_o == LV_LOW && bp1_o != LV_MID));

  // R6: a segment code is never mid and never the unused code
  p_seg_swing_r6: assert property (@(posedge clk) disable iff (rst)
    (seg_o[1:0] == LV_LOW || seg_o[1:0] == LV_HIGH));

endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
  import lcdseq_pkg::*;
#(
  parameter int NSEG      = 32,
  parameter int PHASE_DIV = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mux2_i,
  input  logic              slave_i,
  input  logic [NSEG-1:0]   bank_a_i,
  input  logic [NSEG-1:0]   bank_b_i,
  input  logic [1:0]        bp1_in_i,
  input  logic [1:0]        bp2_in_i,
  output logic [1:0]        bp1_o,
  output logic [1:0]        bp2_o,
  output logic              bp_oe_o,
  output logic [2*NSEG-1:0] seg_o
);

  logic [1:0]      phase;
  logic            mode;
  logic            wrap;
  logic [NSEG-1:0] disp_a;
  logic [NSEG-1:0] disp_b;

  lcdseq_timebase #(.PHASE_DIV(PHASE_DIV)) u_time (
    .clk      (clk),
    .rst      (rst),
    .mux2_i   (mux2_i),
    .slave_i  (slave_i),
    .bp1_in_i (bp1_in_i),
    .bp2_in_i (bp2_in_i),
    .phase_o  (phase),
    .mode_o   (mode),
    .wrap_o   (wrap)
  );

  lcdseq_frame_store #(.NSEG(NSEG)) u_store (
    .clk      (clk),
    .rst      (rst),
    .load_i   (wrap),
    .bank_a_i (bank_a_i),
    .bank_b_i (bank_b_i),
    .disp_a_o (disp_a),
    .disp_b_o (disp_b)
  );

  lcdseq_drive #(.NSEG(NSEG)) u_drive (
    .clk      (clk),
    .rst      (rst),
    .phase_i  (phase),
    .mode_i   (mode),
    .disp_a_i (disp_a),
    .disp_b_i (disp_b),
    .bp1_o    (bp1_o),
    .bp2_o    (bp2_o),
    .seg_o    (seg_o)
  );

  always_ff @(posedge clk) begin
    if (rst) bp_oe_o <= 1'b0;
    else     bp_oe_o <= ~slave_i;
  end

  // R8: a follower never drives its backplane pins
  p_release_bp_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(slave_i)) |-> !bp_oe_o);

  // R2: backplane codes stay within the three legal levels
  p_legal_bp_r2: assert property (@(posedge clk) disable iff (rst)
    (bp1_o != 2'b11 && bp2_o != 2'b11));

endmodule

// File: tb/lcd_mux_sequencer_test.sv
module lcd_mux_sequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 32;
  localparam int DIV  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mux2_i = 1'b0;
  logic              slave_i = 1'b0;
  logic [NSEG-1:0]   bank_a_i = '0;
  logic [NSEG-1:0]   bank_b_i = '0;
  logic [1:0]        bp1_in_i = 2'b01;
  logic [1:0]        bp2_in_i = 2'b01;
  logic [1:0]        bp1_o;
  logic [1:0]        bp2_o;
  logic              bp_oe_o;
  logic [2*NSEG-1:0] seg_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_mux_sequencer #(.NSEG(NSEG), .PHASE_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .mux2_i(mux2_i), .slave_i(slave_i),
    .bank_a_i(bank_a_i), .bank_b_i(bank_b_i),
    .bp1_in_i(bp1_in_i), .bp2_in_i(bp2_in_i),
    .bp1_o(bp1_o), .bp2_o(bp2_o), .bp_oe_o(bp_oe_o), .seg_o(seg_o)
  );

  localparam logic [1:0] LO = 2'b00, MI = 2'b01, HI = 2'b10;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [1:0] act_of(input int p);
    return (p % 2 == 0) ? HI : LO;
  endfunction

  function automatic logic [2*NSEG-1:0] exp_seg(input bit m, input int p,
                                                input logic [NSEG-1:0] a, input logic [NSEG-1:0] b);
    logic [2*NSEG-1:0] v;
    for (int i = 0; i < NSEG; i++) begin
      logic on;
      on = (m && p >= 2) ? b[i] : a[i];
      v[2*i +: 2] = on ? ((act_of(p) == HI) ? LO : HI) : act_of(p);
    end
    return v;
  endfunction

  task automatic check_phase(input string tag, input bit m, input int p, input bit chk_bp,
                             input logic [NSEG-1:0] a, input logic [NSEG-1:0] b);
    logic [1:0] e1, e2;
    if (!m) begin e1 = act_of(p); e2 = LO; end
    else if (p < 2) begin e1 = act_of(p); e2 = MI; end
    else begin e1 = MI; e2 = act_of(p); end
    if (chk_bp) begin
      check({tag, " bp1"}, 128'(bp1_o), 128'(e1));
      check({tag, " bp2"}, 128'(bp2_o), 128'(e2));
    end
    check({tag, " seg"}, 128'(seg_o), 128'(exp_seg(m, p, a, b)));
  endtask

  task automatic do_reset;
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
  endtask

  localparam logic [NSEG-1:0] PA = 32'hA5C3_0F01;
  localparam logic [NSEG-1:0] PB = 32'h3C96_F00E;

  // R1 R2
  task automatic t_reset;
    mux2_i = 1'b0; slave_i = 1'b0; bank_a_i = PA; bank_b_i = PB;
    rst = 1'b1;
    tick(3);
    check("R1 reset bp1 low", 128'(bp1_o), 128'(LO));
    check("R1 reset bp2 low", 128'(bp2_o), 128'(LO));
    check("R1 reset seg low", 128'(seg_o), 128'(0));
    check("R1 reset oe", 128'(bp_oe_o), 128'(0));
    rst = 1'b0;
    tick(1);
    check("R8 master drives bp", 128'(bp_oe_o), 128'(1));
  endtask

  // R3 R4
  task automatic t_static;
    mux2_i = 1'b0; slave_i = 1'b0; bank_a_i = PA; bank_b_i = PB;
    do_reset;
    tick(1); check_phase("R1 R3 static ph0 blank", 0, 0, 1, '0, '0);
    tick(3); check_phase("R3 static ph0 still held", 0, 0, 1, '0, '0);
    tick(1); check_phase("R3 static ph1 blank", 0, 1, 1, '0, '0);
    tick(4); check_phase("R4 static ph0 data", 0, 0, 1, PA, PB);
    tick(4); check_phase("R4 static ph1 data", 0, 1, 1, PA, PB);
  endtask

  // R5 R6
  task automatic t_mux2;
    mux2_i = 1'b1; slave_i = 1'b0; bank_a_i = PA; bank_b_i = PB;
    do_reset;
    tick(1);
    for (int p = 0; p < 4; p++) begin
      check_phase($sformatf("R5 mux blank ph%0d", p), 1, p, 1, '0, '0);
      tick(4);
    end
    for (int p = 0; p < 4; p++) begin
      check_phase($sformatf("R6 mux data ph%0d", p), 1, p, 1, PA, PB);
      tick(4);
    end
  endtask

  // R7: bank change on the capture edge versus one cycle later
  task automatic t_boundary;
    logic [NSEG-1:0] a1, b1, a2, b2;
    a1 = 32'h0000_FFFF; b1 = 32'hFFFF_0000; a2 = 32'h1234_5678; b2 = 32'h8765_4321;
    mux2_i = 1'b1; slave_i = 1'b0; bank_a_i = PA; bank_b_i = PB;
    do_reset;
    tick(15);
    bank_a_i = a1; bank_b_i = b1;
    tick(1);
    bank_a_i = a2; bank_b_i = b2;
    tick(1);
    for (int p = 0; p < 4; p++) begin
      check_phase($sformatf("R7 captured frame ph%0d", p), 1, p, 1, a1, b1);
      tick(4);
    end
    check_phase("R7 late change next frame", 1, 0, 1, a2, b2);
  endtask

  // R10
  task automatic t_mode_change;
    logic [NSEG-1:0] a3;
    a3 = 32'hDEAD_BEEF;
    mux2_i = 1'b1; slave_i = 1'b0; bank_a_i = PA; bank_b_i = PB;
    do_reset;
    tick(17);
    check_phase("R6 before switch", 1, 0, 1, PA, PB);
    tick(2);
    mux2_i = 1'b0; bank_a_i = a3;
    tick(2);
    check_phase("R10 restart static ph0", 0, 0, 1, a3, PB);
    tick(3);
    check_phase("R10 full phase after restart", 0, 0, 1, a3, PB);
    tick(1);
    check_phase("R10 static ph1", 0, 1, 1, a3, PB);
  endtask

  // R8 R9
  task automatic t_slave;
    mux2_i = 1'b1; slave_i = 1'b1; bank_a_i = PA; bank_b_i = PB;
    bp1_in_i = MI; bp2_in_i = MI;
    do_reset;
    tick(2);
    check("R8 slave releases bp", 128'(bp_oe_o), 128'(0));
    check_phase("R9 slave invalid holds ph0", 1, 0, 0, '0, '0);
    bp1_in_i = LO; bp2_in_i = MI;
    tick(1); check_phase("R8 slave latency", 1, 0, 0, '0, '0);
    tick(1); check_phase("R8 slave ph1", 1, 1, 0, '0, '0);
    bp1_in_i = MI; bp2_in_i = HI;
    tick(2); check_phase("R8 slave ph2", 1, 2, 0, '0, '0);
    bp1_in_i = MI; bp2_in_i = LO;
    tick(2); check_phase("R8 slave ph3", 1, 3, 0, '0, '0);
    bp1_in_i = HI; bp2_in_i = MI;
    tick(2); check_phase("R8 slave ph0 captured", 1, 0, 0, PA, PB);
    bp1_in_i = LO; bp2_in_i = MI;
    tick(2); check_phase("R8 slave ph1 data", 1, 1, 0, PA, PB);
    bp1_in_i = HI; bp2_in_i = HI;
    tick(2); check_phase("R9 slave bad pattern holds", 1, 1, 0, PA, PB);
    bp1_in_i = MI; bp2_in_i = MI;
    tick(2); check_phase("R9 slave all mid holds", 1, 1, 0, PA, PB);
    bp1_in_i = MI; bp2_in_i = HI;
    tick(2); check_phase("R8 slave ph2 data", 1, 2, 0, PA, PB);
    check("R8 slave still released", 128'(bp_oe_o), 128'(0));
    slave_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_static;
    t_mux2;
    t_boundary;
    t_mode_change;
    t_slave;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule